// File: doc/BRIEF.md
# Serial Receiver with Sticky Framing Error

This block is the receive half of an asynchronous serial port of the kind found in small 8-bit controllers. It watches a serial input line, counts an external tick that runs at sixteen times the bit rate, and takes the value of each bit as a majority vote of three samples around the middle of the bit. It assembles either 8-bit frames (one start bit, eight data bits, one stop bit) or 9-bit frames (one start bit, nine data bits, one stop bit). Data bits arrive least significant bit first. When a frame is complete, the received byte is placed in a data register and a receive-complete flag is raised.

A stop bit that reads low is a framing error. The error is kept in a sticky flag that only software clears. That flag has no register bit of its own. It shares the top bit of the control register with the high mode-select bit. A view-select bit in a second register decides which of the two storage bits a read returns and a write updates. Software drives the block through a small register port with address, write strobe and write data, and a read data path that does not wait on a clock.

Register layout:
- Address 0, control:
  - bit 7: mode-high or error flag
  - bit 6: mode-low
  - bit 4: receive enable
  - bit 2: received ninth/stop bit
  - bit 0: receive-complete
- Address 1, view select: bit 6.
- Address 2, data: read only.

Bits not named here read as 0.

Top module: `serial_rx_fe`

## Requirements
- R1: After reset, the control register, the view-select register and the data register all read 0.
- R2: With mode bits {bit7 storage, bit6} = 01 and receive enable set, a frame of 8 data bits sent LSB first is stored in the data register. The stop bit value is copied to control bit 2, and control bit 0 is set at the stop bit.
- R3: With mode bits 10 or 11, frames carry 9 data bits. The low 8 go to the data register, and the ninth goes to control bit 2.
- R4: When view select (address 1 bit 6) is 1, a stop bit sampled low sets the error flag, and control bit 7 then reads 1. This applies in all three receiving modes.
- R5: The error flag stays set through later frames with a good stop bit. It clears only on a control write with bit 7 = 0 while view select is 1.
- R6: A control write updates only the mode-high storage when view select is 0, and only the error flag when view select is 1. A read of bit 7 returns whichever of the two the view select names.
- R7: With view select 0, a bad stop bit still completes reception and sets bit 0, but the stored error flag is left unchanged.
- R8: A low pulse on the line that has ended by the middle of the start bit is discarded. No receive-complete is raised, and the data register is not changed.
- R9: A disturbance on the line that reaches only one of the three mid-bit samples does not change the received bit value.
- R10: With receive enable (control bit 4) at 0, or with mode bits 00, a frame on the line leaves the control and data registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| wr | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational on addr |

## Verification
The hardest state to reach is the error flag while it is hidden: it is set or cleared through one view, and then a second frame or a write arrives through the other view. The stimulus moves the view-select bit in the middle of a sequence of frames. It raises the flag with a bad stop bit under view 1, switches to view 0 to rewrite the mode bits, and then switches back to show that the flag survived. Glitch and spike cases are timed against the 16-tick bit period, so that a disturbance covers only the start-bit midpoint or exactly one of the three votes.

// File: rtl/serial_rx_fe.sv
module serial_rx_fe #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] SMP0 = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] SMP1 = CW'(OSR/2);
  localparam logic [CW-1:0] SMP2 = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [3:0] bitn;
  logic [8:0] shreg;
  logic [7:0] rbuf;
  logic rx_s1, rx_s2, smp_a, smp_b;
  logic sm0, sm1, ren, rb8, ri, fe, fsel;

  wire maj     = (smp_a & smp_b) | (smp_a & rx_s2) | (smp_b & rx_s2);
  wire mode1   = !sm0 && sm1;
  wire active  = ren && (sm0 || sm1);
  wire [3:0] lastbit = sm0 ? 4'd8 : 4'd7;
  wire ctrl_wr = wr && addr == 2'd0;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[5], wdata[3], wdata[1]};

  always_comb begin
    case (addr)
      2'd0:    rdata = {fsel ? fe : sm0, sm1, 1'b0, ren, 1'b0, rb8, 1'b0, ri};
      2'd1:    rdata = {1'b0, fsel, 6'b0};
      2'd2:    rdata = rbuf;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      bitn <= '0;
      shreg <= '0;
      rbuf <= '0;
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
      smp_a <= 1'b1;
      smp_b <= 1'b1;
      {sm0, sm1, ren, rb8, ri, fe, fsel} <= '0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;

      if (ctrl_wr) begin
        if (fsel) fe <= wdata[7];
        else      sm0 <= wdata[7];
        sm1 <= wdata[6];
        ren <= wdata[4];
        rb8 <= wdata[2];
        ri  <= wdata[0];
      end
      if (wr && addr == 2'd1) fsel <= wdata[6];

      if (tick16) begin
        if (st == S_IDLE) begin
          if (active && !rx_s2) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == SMP0) smp_a <= rx_s2;
          if (cnt == SMP1) smp_b <= rx_s2;
          if (cnt == SMP2) begin
            case (st)
              S_START: if (maj) st <= S_IDLE;
              S_DATA:  shreg[bitn] <= maj;
              S_STOP: begin
                ri   <= 1'b1;
                rbuf <= shreg[7:0];
                rb8  <= mode1 ? maj : shreg[8];
                if (fsel && !maj) fe <= 1'b1;
                st   <= S_IDLE;
              end
              default: ;
            endcase
          end
          if (cnt == LAST) begin
            cnt <= '0;
            if (st == S_START) begin
              st   <= S_DATA;
              bitn <= '0;
            end else if (st == S_DATA) begin
              bitn <= bitn + 1'b1;
              if (bitn == lastbit) st <= S_STOP;
            end
          end
        end
      end
    end
  end

  AST_RI_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && tick16 && cnt == SMP2) |=> ri); // R2
  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !(ctrl_wr && fsel)) |=> fe); // R5
  AST_SM0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && fsel) |=> sm0 == $past(sm0)); // R6
  AST_FE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    !fsel |=> fe == $past(fe)); // R7
  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick16 && cnt == SMP2 && maj) |=> st == S_IDLE); // R8
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !active) |=> st == S_IDLE); // R10
endmodule

// File: tb/serial_rx_fe_tb.sv
module serial_rx_fe_tb;
  logic clk = 0, rst_n = 0, tick16 = 0, rxd = 1, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  int total = 0, bad = 0, tcnt = 0;
  bit finished = 0;

  typedef struct { string tag; logic [7:0] data; logic [7:0] ctrl; } exp_t;
  exp_t q[$];
  event got, mon_done;

  serial_rx_fe u_dut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    tick16 <= (tcnt == 3);
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic drive_bit(logic v, int spike);
    if (spike) begin
      rxd = v;  repeat (32) @(negedge clk);
      rxd = ~v; repeat (4)  @(negedge clk);
      rxd = v;  repeat (28) @(negedge clk);
    end else begin
      rxd = v; repeat (64) @(negedge clk);
    end
  endtask

  task automatic send(logic [8:0] d, int nb, logic stopv, int spike_bit);
    @(negedge clk);
    drive_bit(1'b0, 0);
    for (int i = 0; i < nb; i++) drive_bit(d[i], i == spike_bit);
    drive_bit(stopv, 0);
    rxd = 1; repeat (16) @(negedge clk);
  endtask

  task automatic frame(string tag, logic [8:0] d, int nb, logic stopv, int spike_bit,
                       logic [7:0] ectrl);
    exp_t e;
    e.tag = tag; e.data = d[7:0]; e.ctrl = ectrl;
    q.push_back(e);
    send(d, nb, stopv, spike_bit);
    -> got;
    @(mon_done);
  endtask

  initial begin
    forever begin
      exp_t e;
      logic [7:0] v;
      @(got);
      e = q.pop_front();
      rreg(2'd2, v); chk({e.tag, " data"}, v, e.data);
      rreg(2'd0, v); chk({e.tag, " ctrl"}, v, e.ctrl);
      wreg(2'd0, v & 8'hFE);
      -> mon_done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    rreg(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rreg(2'd1, v); chk("R1 sel", v, 8'h00);
    rreg(2'd2, v); chk("R1 data", v, 8'h00);

    wreg(2'd0, 8'h50);
    frame("R2 mode1 good", 9'h0A5, 8, 1'b1, -1, 8'h55);
    frame("R7 hidden bad stop", 9'h03C, 8, 1'b0, -1, 8'h51);
    wreg(2'd1, 8'h40);
    rreg(2'd0, v); chk("R7 fe untouched", v, 8'h50);

    frame("R4 bad stop sets fe", 9'h081, 8, 1'b0, -1, 8'hD1);
    frame("R5 fe survives good frame", 9'h07E, 8, 1'b1, -1, 8'hD5);

    wreg(2'd1, 8'h00);
    rreg(2'd0, v); chk("R6 view sm0", v, 8'h54);
    wreg(2'd0, 8'hD4);
    wreg(2'd1, 8'h40);
    rreg(2'd0, v); chk("R6 fe kept on sm0 write", v, 8'hD4);
    wreg(2'd0, 8'h54);
    rreg(2'd0, v); chk("R5 fe cleared by write", v, 8'h54);
    wreg(2'd1, 8'h00);
    rreg(2'd0, v); chk("R6 sm0 kept on fe write", v, 8'hD4);

    frame("R3 mode3 ninth=1", 9'h15A, 9, 1'b1, -1, 8'hD5);
    frame("R3 mode3 ninth=0", 9'h0C3, 9, 1'b1, -1, 8'hD1);
    wreg(2'd1, 8'h40);
    frame("R4 mode3 bad stop", 9'h10F, 9, 1'b0, -1, 8'hD5);
    wreg(2'd0, 8'h54);
    wreg(2'd1, 8'h00);

    wreg(2'd0, 8'h90);
    frame("R3 mode2 ninth=1", 9'h166, 9, 1'b1, -1, 8'h95);

    wreg(2'd0, 8'h50);
    @(negedge clk);
    rxd = 0; repeat (16) @(negedge clk);
    rxd = 1; repeat (200) @(negedge clk);
    rreg(2'd0, v); chk("R8 glitch no ri", v, 8'h50);
    rreg(2'd2, v); chk("R8 glitch data kept", v, 8'h66);

    frame("R9 spike on one", 9'h0FF, 8, 1'b1, 3, 8'h55);
    frame("R9 spike on zero", 9'h000, 8, 1'b1, 5, 8'h55);

    wreg(2'd0, 8'h40);
    send(9'h012, 8, 1'b1, -1);
    rreg(2'd0, v); chk("R10 ren off ctrl", v, 8'h40);
    rreg(2'd2, v); chk("R10 ren off data", v, 8'h00);
    wreg(2'd0, 8'h10);
    send(9'h034, 8, 1'b1, -1);
    rreg(2'd0, v); chk("R10 mode0 ctrl", v, 8'h10);
    rreg(2'd2, v); chk("R10 mode0 data", v, 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule